// File: doc/BRIEF.md
# Shared-Pin Serial Register Port (I2C / SPI)

This block is a slave port that lets an external host read and write an internal byte-wide register file over one set of shared pins. After reset it behaves as an I2C-compatible target. A falling edge on the chip-select pin moves it into SPI mode for good; only another reset brings it back to I2C. In both modes a transfer sets a register pointer once, and then every data byte moves the pointer on by one. The register file is outside the block and is reached through an address, a write-data byte, a one-cycle write strobe and a read-data byte that the register file returns combinationally for the current address.

All pins are sampled on the system clock through two-flop synchronizers. The bus clock and data are oversampled and their edges are detected in the system domain, so the system clock must run well above the serial bit rate. The same pin is the I2C address strap while the port is in I2C mode and the SPI data output while it is in SPI mode. The block therefore provides an output-enable for that pin, and a second one that pulls SDA low for its open-drain driver.

The I2C engine uses the states IDLE, DEVADDR, DEVACK, REGADDR, REGACK, WRDATA, WRACK, RDDATA, RDACK and IGNORE. A START enters DEVADDR from any state, and a STOP returns to IDLE from any state. DEVADDR goes to DEVACK on an address match and to IGNORE on a mismatch. DEVACK goes to REGADDR for a write or to RDDATA for a read. REGADDR goes to REGACK, and REGACK goes to WRDATA. WRDATA and WRACK alternate. RDDATA and RDACK alternate while the host acknowledges, and a NACK sends RDACK to IGNORE. The SPI engine uses the states IDLE, CMD, WR and RD. Chip select low moves IDLE to CMD. CMD goes to WR or RD according to bit 7 of the first byte. Chip select high returns the engine to IDLE.

Top module: `shared_regport`

## Requirements
- R1: After reset the port is in I2C mode, SDA is not pulled low, the strap/SO pin is not driven, and no write strobe occurs.
- R2: A high-to-low change on chip select puts the port in SPI mode, which holds until the next reset; I2C traffic in SPI mode gets no ACK and causes no register write.
- R3: The I2C target address is 7'h16 with the strap low and 7'h17 with the strap high; a matching address byte is acknowledged by pulling SDA low during the ninth clock.
- R4: An I2C write (address with R/W bit 0, register byte, data bytes) writes each data byte to the register byte's address plus its position, and each byte is acknowledged.
- R5: An I2C address byte that does not match is not acknowledged; SDA stays released and no register is written until the next START or STOP.
- R6: After a write that sets the pointer, a repeated START with the R/W bit 1 returns bytes MSB first from incrementing addresses while the host ACKs; a host NACK ends the read.
- R7: The register pointer wraps from 0xFF to 0x00 during auto-increment.
- R8: The first SPI byte is sent MSB first; its bit 7 selects read (1) or write (0), and bits 6:0 give the register address with the upper address bit zero.
- R9: Each further SPI byte, while chip select stays low, is written to the next register address, MSB first.
- R10: SPI read data is shifted out MSB first, changes after a falling clock edge and is valid at the rising edge, with the clock idling either low (mode 0) or high (mode 3).
- R11: The SO output enable is active only in SPI mode with chip select low, and drops after chip select returns high.
- R12: Every register write is a single-cycle strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_sck | input | 1 | Shared serial clock pin (I2C SCL / SPI SCK) |
| sda_si | input | 1 | Shared data pin as seen on the line (I2C SDA / SPI SI) |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| sa_so_in | input | 1 | Level on the strap/SO pin, used as the I2C address LSB |
| so_out | output | 1 | SPI serial data output |
| so_oe | output | 1 | Output enable of the strap/SO pin |
| cs_n | input | 1 | SPI chip select, active low; its first fall selects SPI mode |
| reg_addr | output | 8 | Register file address |
| reg_wdata | output | 8 | Register file write data |
| reg_we | output | 1 | Register file write strobe |
| reg_rdata | input | 8 | Register file read data for reg_addr |

## Verification
The I2C side is driven with multi-byte writes and reads under both strap levels. Each transfer is paired with a transfer to the other address, which separates address matching from the shared datapath. Start addresses 0xFE and 0xFF show whether the pointer wraps or saturates. The SPI side is tried with writes in mode 0 and reads in both clock polarities; the two polarities isolate the falling-edge load of the first read byte. A read at 0x7F shows how the 7-bit header address is extended. A final I2C transfer after the mode switch, followed by a reset, shows that the mode stays locked and is then released.

// File: rtl/regport_pkg.sv
package regport_pkg;
    typedef enum logic [3:0] {
        I_IDLE, I_DEVADDR, I_DEVACK, I_REGADDR, I_REGACK,
        I_WRDATA, I_WRACK, I_RDDATA, I_RDACK, I_IGNORE
    } i2c_state_t;

    typedef enum logic [1:0] {S_IDLE, S_CMD, S_WR, S_RD} spi_state_t;
endpackage

// File: rtl/regport_sync.sv
module regport_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] INIT = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta <= INIT[i];
                q[i] <= INIT[i];
            end else begin
                meta <= d[i];
                q[i] <= meta;
            end
        end
    end
endmodule

// File: rtl/regport_i2c.sv
module regport_i2c
    import regport_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8,
    parameter logic [5:0] DEV_HI = 6'b001011
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          scl,
    input  logic          sda,
    input  logic          strap,
    output logic          sda_oe,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata,
    output logic          we,
    input  logic [DW-1:0] rdata
);
    localparam int CW = $clog2(DW) + 1;

    i2c_state_t    st, nxt;
    logic          scl_q, sda_q, mack;
    logic [DW-1:0] sh;
    logic [CW-1:0] cnt;
    logic [AW-1:0] ptr;

    wire scl_rise = scl & ~scl_q;
    wire scl_fall = ~scl & scl_q;
    wire start_c  = scl & scl_q & sda_q & ~sda;
    wire stop_c   = scl & scl_q & ~sda_q & sda;
    wire byte_end = scl_fall && (cnt == CW'(DW));

    always_comb begin
        nxt = st;
        if (!en)          nxt = I_IDLE;
        else if (start_c) nxt = I_DEVADDR;
        else if (stop_c)  nxt = I_IDLE;
        else begin
            unique case (st)
                I_IDLE, I_IGNORE: nxt = st;
                I_DEVADDR: if (byte_end)
                    nxt = (sh[DW-1:1] == {DEV_HI, strap}) ? I_DEVACK : I_IGNORE;
                I_DEVACK:  if (scl_fall) nxt = sh[0] ? I_RDDATA : I_REGADDR;
                I_REGADDR: if (byte_end) nxt = I_REGACK;
                I_REGACK:  if (scl_fall) nxt = I_WRDATA;
                I_WRDATA:  if (byte_end) nxt = I_WRACK;
                I_WRACK:   if (scl_fall) nxt = I_WRDATA;
                I_RDDATA:  if (scl_fall && cnt == CW'(DW - 1)) nxt = I_RDACK;
                I_RDACK:   if (scl_fall) nxt = mack ? I_RDDATA : I_IGNORE;
                default:   nxt = I_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= I_IDLE;
        else        st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {scl_q, sda_q} <= 2'b11;
            sh   <= '0;
            cnt  <= '0;
            ptr  <= '0;
            we   <= 1'b0;
            mack <= 1'b0;
        end else begin
            {scl_q, sda_q} <= {scl, sda};
            we <= 1'b0;
            if (start_c) cnt <= '0;
            else begin
                unique case (st)
                    I_DEVADDR, I_REGADDR, I_WRDATA: begin
                        if (scl_rise) begin
                            sh  <= {sh[DW-2:0], sda};
                            cnt <= cnt + 1'b1;
                        end
                        if (byte_end) begin
                            cnt <= '0;
                            if (st == I_REGADDR) ptr <= AW'(sh);
                            if (st == I_WRDATA)  we  <= 1'b1;
                        end
                    end
                    I_WRACK: if (scl_fall) ptr <= ptr + 1'b1;
                    I_DEVACK: if (scl_fall && sh[0]) begin
                        sh  <= rdata;
                        ptr <= ptr + 1'b1;
                        cnt <= '0;
                    end
                    I_RDDATA: if (scl_fall) begin
                        sh  <= {sh[DW-2:0], 1'b0};
                        cnt <= cnt + 1'b1;
                    end
                    I_RDACK: begin
                        if (scl_rise) mack <= ~sda;
                        if (scl_fall && mack) begin
                            sh  <= rdata;
                            ptr <= ptr + 1'b1;
                            cnt <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        addr   = ptr;
        wdata  = sh;
        sda_oe = (st == I_DEVACK) || (st == I_REGACK) || (st == I_WRACK)
              || ((st == I_RDDATA) && !sh[DW-1]);
    end
endmodule

// File: rtl/regport_spi.sv
module regport_spi
    import regport_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          sck,
    input  logic          si,
    input  logic          cs_n,
    output logic          so,
    output logic          so_oe,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata,
    output logic          we,
    input  logic [DW-1:0] rdata
);
    localparam int CW = $clog2(DW);

    spi_state_t    st, nxt;
    logic          sck_q;
    logic [DW-1:0] sh;
    logic [CW-1:0] cnt;
    logic [AW-1:0] ptr;

    wire sck_rise = sck & ~sck_q;
    wire sck_fall = ~sck & sck_q;
    wire last_bit = sck_rise && (cnt == CW'(DW - 1));

    always_comb begin
        nxt = st;
        if (!en || cs_n) nxt = S_IDLE;
        else begin
            unique case (st)
                S_IDLE:     nxt = S_CMD;
                S_CMD:      if (last_bit) nxt = sh[DW-2] ? S_RD : S_WR;
                S_WR, S_RD: nxt = st;
                default:    nxt = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            sh    <= '0;
            cnt   <= '0;
            ptr   <= '0;
            we    <= 1'b0;
        end else begin
            sck_q <= sck;
            we    <= 1'b0;
            if (we) ptr <= ptr + 1'b1;
            unique case (st)
                S_IDLE: cnt <= '0;
                S_CMD, S_WR: if (sck_rise) begin
                    sh  <= {sh[DW-2:0], si};
                    cnt <= cnt + 1'b1;
                    if (last_bit && st == S_CMD) ptr <= AW'({sh[DW-3:0], si});
                    if (last_bit && st == S_WR)  we  <= 1'b1;
                end
                S_RD: begin
                    if (sck_rise) cnt <= cnt + 1'b1;
                    if (sck_fall) begin
                        if (cnt == '0) begin
                            sh  <= rdata;
                            ptr <= ptr + 1'b1;
                        end else begin
                            sh <= {sh[DW-2:0], 1'b0};
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        addr  = ptr;
        wdata = sh;
        so    = sh[DW-1];
        so_oe = (st == S_RD);
    end
endmodule

// File: rtl/shared_regport.sv
module shared_regport #(
    parameter int AW = 8,
    parameter int DW = 8,
    parameter logic [5:0] DEV_HI = 6'b001011
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_sck,
    input  logic          sda_si,
    output logic          sda_oe,
    input  logic          sa_so_in,
    output logic          so_out,
    output logic          so_oe,
    input  logic          cs_n,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          reg_we,
    input  logic [DW-1:0] reg_rdata
);
    logic          scl_s, sda_s, cs_s, sa_s, cs_q, spi_mode;
    logic [AW-1:0] i_addr, s_addr;
    logic [DW-1:0] i_wdata, s_wdata;
    logic          i_we, s_we;

    regport_sync #(.W(4), .INIT(4'hF)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({scl_sck, sda_si, cs_n, sa_so_in}),
        .q({scl_s, sda_s, cs_s, sa_s})
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q     <= 1'b1;
            spi_mode <= 1'b0;
        end else begin
            cs_q <= cs_s;
            if (cs_q && !cs_s) spi_mode <= 1'b1;
        end
    end

    regport_i2c #(.AW(AW), .DW(DW), .DEV_HI(DEV_HI)) u_i2c (
        .clk(clk), .rst_n(rst_n), .en(!spi_mode),
        .scl(scl_s), .sda(sda_s), .strap(sa_s), .sda_oe(sda_oe),
        .addr(i_addr), .wdata(i_wdata), .we(i_we), .rdata(reg_rdata)
    );

    regport_spi #(.AW(AW), .DW(DW)) u_spi (
        .clk(clk), .rst_n(rst_n), .en(spi_mode),
        .sck(scl_s), .si(sda_s), .cs_n(cs_s),
        .so(so_out), .so_oe(so_oe),
        .addr(s_addr), .wdata(s_wdata), .we(s_we), .rdata(reg_rdata)
    );

    always_comb begin
        reg_addr  = spi_mode ? s_addr  : i_addr;
        reg_wdata = spi_mode ? s_wdata : i_wdata;
        reg_we    = spi_mode ? s_we    : i_we;
    end
endmodule

// File: rtl/shared_regport_chk.sv
module shared_regport_chk (
    input logic clk,
    input logic rst_n,
    input logic spi_mode,
    input logic sda_oe,
    input logic so_oe,
    input logic reg_we
);
    assert_mode_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_mode |=> spi_mode);

    assert_i2c_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_mode |=> !sda_oe);

    assert_so_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> spi_mode);

    assert_we_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    assert_pins_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(sda_oe && so_oe));
endmodule

bind shared_regport shared_regport_chk u_chk (
    .clk(clk), .rst_n(rst_n), .spi_mode(spi_mode),
    .sda_oe(sda_oe), .so_oe(so_oe), .reg_we(reg_we)
);

// File: tb/shared_regport_tb.sv
module shared_regport_tb;
    localparam int Q = 20;
    localparam int H = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1, m_cs = 1'b1, strap = 1'b0;
    logic sda_oe, so_out, so_oe, reg_we;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic [7:0] mem [256];
    logic [7:0] shadow [256];
    int checks = 0, errors = 0;

    logic [15:0] exp_wr_q[$];
    string       wr_tag_q[$];
    logic [7:0]  exp_rd_q[$];
    logic [7:0]  got_q[$];
    string       rd_tag_q[$];

    wire sda_line = m_sda & ~sda_oe;
    wire so_pin   = so_oe ? so_out : strap;

    always #2.5 clk = ~clk;

    shared_regport u_dut (
        .clk(clk), .rst_n(rst_n), .scl_sck(m_scl), .sda_si(sda_line),
        .sda_oe(sda_oe), .sa_so_in(so_pin), .so_out(so_out), .so_oe(so_oe),
        .cs_n(m_cs), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata)
    );

    assign reg_rdata = mem[reg_addr];
    always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compares design output against scoreboard queues
    always @(negedge clk) begin
        if (rst_n && reg_we) begin
            if (exp_wr_q.size() == 0)
                check(0, "R5/R2 unexpected write", {reg_addr, reg_wdata}, 16'h0);
            else begin
                logic [15:0] e;
                string t;
                e = exp_wr_q.pop_front();
                t = wr_tag_q.pop_front();
                check({reg_addr, reg_wdata} == e, t, {reg_addr, reg_wdata}, e);
            end
        end
        if (got_q.size() > 0) begin
            logic [7:0] g, e;
            string t;
            g = got_q.pop_front();
            t = rd_tag_q.pop_front();
            if (exp_rd_q.size() == 0) check(0, t, {8'h0, g}, 16'h0);
            else begin
                e = exp_rd_q.pop_front();
                check(g == e, t, {8'h0, g}, {8'h0, e});
            end
        end
    end

    task automatic wq(); repeat (Q) @(posedge clk); endtask
    task automatic wh(); repeat (H) @(posedge clk); endtask

    task automatic i2c_start(); m_sda = 1; wq(); m_scl = 1; wq(); m_sda = 0; wq(); m_scl = 0; wq(); endtask
    task automatic i2c_stop();  m_sda = 0; wq(); m_scl = 1; wq(); m_sda = 1; wq(); endtask

    task automatic i2c_bit(input logic b, output logic s);
        m_sda = b; wq(); m_scl = 1; wq();
        @(negedge clk) s = sda_line;
        wq(); m_scl = 0; wq();
    endtask

    task automatic i2c_wbyte(input logic [7:0] b, output logic ack);
        logic d;
        for (int i = 7; i >= 0; i--) i2c_bit(b[i], d);
        i2c_bit(1'b1, ack);
    endtask

    task automatic i2c_rbyte(input logic last, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin i2c_bit(1'b1, s); b[i] = s; end
        i2c_bit(last, s);
    endtask

    task automatic i2c_write(input logic [6:0] a7, input logic [7:0] ra, input logic [7:0] d [4],
                             input int n, input bit exp_ack, input string tag);
        logic ack;
        i2c_start();
        i2c_wbyte({a7, 1'b0}, ack);
        check(ack == !exp_ack, {tag, " address ack"}, {15'h0, ack}, {15'h0, !exp_ack});
        i2c_wbyte(ra, ack);
        check(ack == !exp_ack, {tag, " register ack"}, {15'h0, ack}, {15'h0, !exp_ack});
        for (int i = 0; i < n; i++) begin
            logic [7:0] a;
            a = ra + 8'(i);
            if (exp_ack) begin
                exp_wr_q.push_back({a, d[i]});
                wr_tag_q.push_back({tag, " write"});
                shadow[a] = d[i];
            end
            i2c_wbyte(d[i], ack);
            check(ack == !exp_ack, {tag, " data ack"}, {15'h0, ack}, {15'h0, !exp_ack});
        end
        i2c_stop();
        wq();
    endtask

    task automatic i2c_read(input logic [6:0] a7, input logic [7:0] ra, input int n, input string tag);
        logic ack;
        logic [7:0] b;
        i2c_start();
        i2c_wbyte({a7, 1'b0}, ack);
        i2c_wbyte(ra, ack);
        i2c_start();
        i2c_wbyte({a7, 1'b1}, ack);
        check(ack == 1'b0, {tag, " read address ack"}, {15'h0, ack}, 16'h0);
        for (int i = 0; i < n; i++) begin
            exp_rd_q.push_back(shadow[8'(ra + 8'(i))]);
            i2c_rbyte(i == n - 1, b);
            got_q.push_back(b);
            rd_tag_q.push_back({tag, " read data"});
        end
        i2c_stop();
        wq();
    endtask

    task automatic spi_byte(input bit m3, input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            if (m3) m_scl = 0;
            m_sda = b[i];
            wh();
            m_scl = 1;
            @(negedge clk) r[i] = so_pin;
            wh();
            if (!m3) m_scl = 0;
        end
    endtask

    task automatic spi_write(input bit m3, input logic [6:0] ra, input logic [7:0] d [4], input int n);
        logic [7:0] r;
        m_scl = m3; wh(); m_cs = 0; wh();
        spi_byte(m3, {1'b0, ra}, r);
        for (int i = 0; i < n; i++) begin
            logic [7:0] a;
            a = {1'b0, ra} + 8'(i);
            exp_wr_q.push_back({a, d[i]});
            wr_tag_q.push_back("R8 R9 spi write");
            shadow[a] = d[i];
            spi_byte(m3, d[i], r);
        end
        wh(); m_cs = 1; wh(); wh();
    endtask

    task automatic spi_read(input bit m3, input logic [6:0] ra, input int n);
        logic [7:0] r;
        m_scl = m3; wh(); m_cs = 0; wh();
        spi_byte(m3, {1'b1, ra}, r);
        for (int i = 0; i < n; i++) begin
            exp_rd_q.push_back(shadow[8'({1'b0, ra} + 8'(i))]);
            spi_byte(m3, 8'h00, r);
            got_q.push_back(r);
            rd_tag_q.push_back(m3 ? "R10 R8 spi read mode3" : "R10 R8 spi read mode0");
        end
        wh(); m_cs = 1; wh(); wh();
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d [4];
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i * 7 + 3);
            shadow[i] = 8'(i * 7 + 3);
        end
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(sda_oe == 0, "R1 sda released in reset", {15'h0, sda_oe}, 16'h0);
        rst_n = 1;
        repeat (10) @(negedge clk);
        check(sda_oe == 0, "R1 sda released", {15'h0, sda_oe}, 16'h0);
        check(so_oe == 0, "R1 so not driven", {15'h0, so_oe}, 16'h0);
        check(reg_we == 0, "R1 no write strobe", {15'h0, reg_we}, 16'h0);

        d = '{8'hA1, 8'hB2, 8'hC3, 8'h00};
        i2c_write(7'h16, 8'h10, d, 3, 1, "R3 R4 strap0");
        d = '{8'h55, 8'h66, 8'h00, 8'h00};
        i2c_write(7'h17, 8'h10, d, 2, 0, "R5 strap0 mismatch");
        i2c_read(7'h16, 8'h10, 3, "R6");

        strap = 1; wq();
        d = '{8'h11, 8'h22, 8'h33, 8'h00};
        i2c_write(7'h17, 8'hFE, d, 3, 1, "R7 R3 strap1 wrap");
        d = '{8'h99, 8'h00, 8'h00, 8'h00};
        i2c_write(7'h16, 8'h00, d, 1, 0, "R5 strap1 mismatch");
        i2c_read(7'h17, 8'hFF, 2, "R7 R6 wrap read");

        d = '{8'h5A, 8'hA5, 8'h3C, 8'h00};
        spi_write(0, 7'h20, d, 3);
        spi_read(1, 7'h20, 3);
        spi_read(0, 7'h7F, 2);
        repeat (10) @(negedge clk);
        check(so_oe == 0, "R11 so released with cs high", {15'h0, so_oe}, 16'h0);
        check(so_pin == strap, "R11 pin shows strap", {15'h0, so_pin}, {15'h0, strap});

        m_scl = 1; m_sda = 1; wq();
        d = '{8'hEE, 8'h00, 8'h00, 8'h00};
        i2c_write(7'h17, 8'h05, d, 1, 0, "R2 i2c locked out");

        rst_n = 0; repeat (4) @(posedge clk); rst_n = 1; wq();
        d = '{8'h77, 8'h00, 8'h00, 8'h00};
        i2c_write(7'h17, 8'h05, d, 1, 1, "R1 i2c after reset");
        i2c_read(7'h17, 8'h05, 1, "R1 readback");

        repeat (20) @(posedge clk);
        check(exp_wr_q.size() == 0, "R4 R9 pending writes", 16'(exp_wr_q.size()), 16'h0);
        check(exp_rd_q.size() == 0, "R6 R10 pending reads", 16'(exp_rd_q.size()), 16'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule